// File: doc/BRIEF.md
# Mode-Selectable Data Cache Controller

This block sits between a processor load/store port and a system bus and fronts a small direct-mapped data cache. Each line holds a tag, a two-bit coherence state (Invalid, Shared, Exclusive, Modified) and 32 bytes of data, kept as four 64-bit words. Processor requests are single 64-bit word reads or full-word writes. The controller looks the request up and then does one of four things: it serves a hit, fetches a whole line with a four-beat burst, performs a single-word external read, or forwards the write to external memory.

Two plain mode pins choose how it behaves. `mode_freeze` stops new lines from being brought in while existing lines keep serving hits. `mode_nowt` set while `mode_freeze` is clear is an illegal combination: the request raises `mode_fault` and touches nothing. The mode pins, `req_wt_page` and `bus_wb_ok` are sampled at the handshakes described below. A write hit to a Shared line can be promoted to Exclusive when the bus reports that the location may be held write-back.

The processor request and the bus request are valid/ready channels. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after a request that needs the bus until that bus operation is complete. The bus request is held stable until `bus_req_ready` is seen. Read data returns on `rsp_valid`, and the fill beats arrive on `bus_rsp_valid`. Neither of these response paths has a back-pressure input: the processor and the controller must each take every beat offered to them.

Top module: `mode_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `req_ready` is high, and `bus_req_valid`, `rsp_valid` and `mode_fault` are low.
- R2: A read that hits in any legal mode returns the stored word on `rsp_valid`/`rsp_rdata` one cycle after acceptance, with no bus request, and `req_ready` stays high.
- R3: A read miss with `mode_freeze`=0 and `mode_nowt`=0 issues one burst read (`bus_req_burst`=1, `bus_req_write`=0) at the line address with bits [4:0] zero. Four beats are taken as words 0..3 in ascending address order. The line becomes valid and the requested word is returned on `rsp_valid` one cycle after the fourth beat.
- R4: A filled line enters Exclusive if `bus_wb_ok` is high during the last fill beat, and Shared otherwise.
- R5: A read miss with `mode_freeze`=1 issues one non-burst read at the word address and returns the single beat on `rsp_valid` one cycle after it arrives. It allocates nothing, so a repeat of the read misses again.
- R6: A write hit in any legal mode updates the cached word, and a later read hit returns the new value.
- R7: A write miss, or a write hit to a Shared line, issues one external write (`bus_req_write`=1, `bus_req_burst`=0) carrying the word address and data. A write miss allocates no line.
- R8: A write hit to an Exclusive or Modified line marks it Modified and issues no bus request.
- R9: A write hit to a Shared line with `mode_nowt`=0 moves the line to Exclusive when `req_wt_page` was low at acceptance and `bus_wb_ok` is high when the external write is accepted. Otherwise the line stays Shared.
- R10: With `mode_freeze`=0 and `mode_nowt`=1, an accepted request pulses `mode_fault` for one cycle, one cycle later. It performs no lookup, bus request, response or state change.
- R11: Switching to `mode_freeze`=1, `mode_nowt`=1 invalidates nothing: lines filled earlier still hit.
- R12: While a bus operation is outstanding `req_ready` is low, and a bus request keeps its address, direction and burst flag until `bus_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_freeze | input | 1 | Stop line fills; hits still served |
| mode_nowt | input | 1 | Second mode bit; illegal when set alone |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address, 8-byte aligned |
| req_wdata | input | DW | Write word |
| req_wt_page | input | 1 | Page requires write-through |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | DW | Read data |
| mode_fault | output | 1 | Illegal mode pulse |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus takes the request |
| bus_req_write | output | 1 | Bus request is a write |
| bus_req_burst | output | 1 | Bus request is a four-beat line read |
| bus_req_addr | output | AW | Bus address |
| bus_req_wdata | output | DW | Bus write data |
| bus_rsp_valid | input | 1 | Read beat valid |
| bus_rsp_data | input | DW | Read beat data |
| bus_wb_ok | input | 1 | Bus reports the location may be held write-back |

## Verification
A hit response and a fault pulse are due one cycle after the acceptance edge. A bus request shows one cycle after acceptance, and a fill or single-read response one cycle after its last beat. After an external write is accepted, `req_ready` returns in the following cycle. The bench drives on falling edges and samples on the falling edge after each of those counted edges. It inserts random stalls on `bus_req_ready` and gaps between beats, and checks that the outputs hold still until the next event. Line state is judged only through later behaviour: whether a write goes to the bus, and whether a read hits.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_BREQ,
    S_BEATS
  } seq_e;
endpackage

// File: rtl/cc_line_store.sv
module cc_line_store
  import cc_pkg::*;
#(
  parameter int LINES = 16,
  parameter int DW    = 64,
  parameter int WPL   = 4,
  parameter int TAGW  = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LINES)-1:0] lk_idx,
  input  logic [$clog2(WPL)-1:0]   lk_sel,
  output logic [TAGW-1:0]          lk_tag,
  output line_st_e                 lk_st,
  output logic [DW-1:0]            lk_word,
  input  logic                     ww_en,
  input  logic [$clog2(LINES)-1:0] ww_idx,
  input  logic [$clog2(WPL)-1:0]   ww_sel,
  input  logic [DW-1:0]            ww_data,
  input  logic                     mw_en,
  input  logic [$clog2(LINES)-1:0] mw_idx,
  input  logic [TAGW-1:0]          mw_tag,
  input  line_st_e                 mw_st
);
  logic [DW-1:0]   data_q [LINES][WPL];
  logic [TAGW-1:0] tag_q  [LINES];
  line_st_e        st_q   [LINES];

  assign lk_tag  = tag_q[lk_idx];
  assign lk_st   = st_q[lk_idx];
  assign lk_word = data_q[lk_idx][lk_sel];

  always_ff @(posedge clk) begin
    if (ww_en) data_q[ww_idx][ww_sel] <= ww_data;
    if (mw_en) tag_q[mw_idx] <= mw_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
    end else if (mw_en) begin
      st_q[mw_idx] <= mw_st;
    end
  end
endmodule

// File: rtl/cc_seq.sv
module cc_seq
  import cc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int LINES = 16,
  parameter int WPL   = 4,
  parameter int TAGW  = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_freeze,
  input  logic                     mode_nowt,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  input  logic                     req_wt_page,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_rdata,
  output logic                     mode_fault,
  output logic                     bus_req_valid,
  input  logic                     bus_req_ready,
  output logic                     bus_req_write,
  output logic                     bus_req_burst,
  output logic [AW-1:0]            bus_req_addr,
  output logic [DW-1:0]            bus_req_wdata,
  input  logic                     bus_rsp_valid,
  input  logic [DW-1:0]            bus_rsp_data,
  input  logic                     bus_wb_ok,
  output logic [$clog2(LINES)-1:0] lk_idx,
  output logic [$clog2(WPL)-1:0]   lk_sel,
  input  logic [TAGW-1:0]          lk_tag,
  input  line_st_e                 lk_st,
  input  logic [DW-1:0]            lk_word,
  output logic                     ww_en,
  output logic [$clog2(LINES)-1:0] ww_idx,
  output logic [$clog2(WPL)-1:0]   ww_sel,
  output logic [DW-1:0]            ww_data,
  output logic                     mw_en,
  output logic [$clog2(LINES)-1:0] mw_idx,
  output logic [TAGW-1:0]          mw_tag,
  output line_st_e                 mw_st
);
  localparam int IDXW  = $clog2(LINES);
  localparam int WSELW = $clog2(WPL);
  localparam int BYTEW = $clog2(DW / 8);
  localparam int OFFW  = WSELW + BYTEW;

  seq_e             st_q;
  logic [IDXW-1:0]  p_idx;
  logic [TAGW-1:0]  p_tag;
  logic [WSELW-1:0] p_sel, beat_q;
  logic [AW-1:0]    p_addr;
  logic [DW-1:0]    p_wdata, rdata_q;
  logic             p_write, p_burst, p_prom, rsp_q, fault_q;

  logic [TAGW-1:0]  r_tag;
  logic [IDXW-1:0]  r_idx;
  logic [WSELW-1:0] r_sel;
  logic accept, illegal, go, hit, wr_hit, silent, beat, last, promote;
  wire  unused_low = ^req_addr[BYTEW-1:0];

  assign r_tag   = req_addr[AW-1 -: TAGW];
  assign r_idx   = req_addr[OFFW +: IDXW];
  assign r_sel   = req_addr[BYTEW +: WSELW];
  assign req_ready = (st_q == S_IDLE);
  assign accept  = req_valid && req_ready;
  assign illegal = !mode_freeze && mode_nowt;
  assign go      = accept && !illegal;
  assign lk_idx  = req_ready ? r_idx : p_idx;
  assign lk_sel  = r_sel;
  assign hit     = (lk_st != LS_INV) && (lk_tag == r_tag);
  assign wr_hit  = go && req_write && hit;
  assign silent  = wr_hit && (lk_st == LS_EXC || lk_st == LS_MOD);
  assign beat    = (st_q == S_BEATS) && bus_rsp_valid;
  assign last    = beat && (!p_burst || beat_q == WSELW'(WPL - 1));
  assign promote = (st_q == S_BREQ) && bus_req_ready && p_write && p_prom && bus_wb_ok;

  // store write ports: the three sources are exclusive by state
  assign ww_en   = wr_hit || (beat && p_burst);
  assign ww_idx  = wr_hit ? r_idx : p_idx;
  assign ww_sel  = wr_hit ? r_sel : beat_q;
  assign ww_data = wr_hit ? req_wdata : bus_rsp_data;
  assign mw_en   = silent || promote || (last && p_burst);
  assign mw_idx  = silent ? r_idx : p_idx;
  assign mw_tag  = silent ? r_tag : p_tag;
  assign mw_st   = silent  ? LS_MOD :
                   promote ? LS_EXC :
                   (bus_wb_ok ? LS_EXC : LS_SHR);

  assign bus_req_valid = (st_q == S_BREQ);
  assign bus_req_write = p_write;
  assign bus_req_burst = p_burst;
  assign bus_req_addr  = p_burst ? {p_addr[AW-1:OFFW], {OFFW{1'b0}}} : p_addr;
  assign bus_req_wdata = p_wdata;
  assign rsp_valid     = rsp_q;
  assign rsp_rdata     = rdata_q;
  assign mode_fault    = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; rsp_q <= 1'b0; fault_q <= 1'b0; beat_q <= '0;
      p_idx <= '0; p_tag <= '0; p_sel <= '0; p_addr <= '0; p_wdata <= '0;
      p_write <= 1'b0; p_burst <= 1'b0; p_prom <= 1'b0; rdata_q <= '0;
    end else begin
      rsp_q   <= 1'b0;
      fault_q <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          if (illegal) begin
            fault_q <= 1'b1;
          end else if (!req_write && hit) begin
            rsp_q   <= 1'b1;
            rdata_q <= lk_word;
          end else if (!silent) begin
            p_idx   <= r_idx;
            p_tag   <= r_tag;
            p_sel   <= r_sel;
            p_addr  <= {req_addr[AW-1:BYTEW], {BYTEW{1'b0}}};
            p_wdata <= req_wdata;
            p_write <= req_write;
            p_burst <= !req_write && !mode_freeze;
            p_prom  <= hit && !mode_nowt && !req_wt_page;
            st_q    <= S_BREQ;
          end
        end
        S_BREQ: if (bus_req_ready) begin
          beat_q <= '0;
          st_q   <= p_write ? S_IDLE : S_BEATS;
        end
        S_BEATS: if (beat) begin
          beat_q <= beat_q + 1'b1;
          if (!p_burst || beat_q == p_sel) rdata_q <= bus_rsp_data;
          if (last) begin
            rsp_q <= 1'b1;
            st_q  <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mode_cache_ctrl.sv
module mode_cache_ctrl
  import cc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_freeze,
  input  logic          mode_nowt,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_wt_page,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mode_fault,
  output logic          bus_req_valid,
  input  logic          bus_req_ready,
  output logic          bus_req_write,
  output logic          bus_req_burst,
  output logic [AW-1:0] bus_req_addr,
  output logic [DW-1:0] bus_req_wdata,
  input  logic          bus_rsp_valid,
  input  logic [DW-1:0] bus_rsp_data,
  input  logic          bus_wb_ok
);
  localparam int WPL   = LINE_BYTES * 8 / DW;
  localparam int IDXW  = $clog2(LINES);
  localparam int WSELW = $clog2(WPL);
  localparam int TAGW  = AW - $clog2(LINE_BYTES) - IDXW;

  logic [IDXW-1:0]  lk_idx, ww_idx, mw_idx;
  logic [WSELW-1:0] lk_sel, ww_sel;
  logic [TAGW-1:0]  lk_tag, mw_tag;
  line_st_e         lk_st, mw_st;
  logic [DW-1:0]    lk_word, ww_data;
  logic             ww_en, mw_en;

  cc_line_store #(.LINES(LINES), .DW(DW), .WPL(WPL), .TAGW(TAGW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_sel(lk_sel), .lk_tag(lk_tag), .lk_st(lk_st), .lk_word(lk_word),
    .ww_en(ww_en), .ww_idx(ww_idx), .ww_sel(ww_sel), .ww_data(ww_data),
    .mw_en(mw_en), .mw_idx(mw_idx), .mw_tag(mw_tag), .mw_st(mw_st)
  );

  cc_seq #(.AW(AW), .DW(DW), .LINES(LINES), .WPL(WPL), .TAGW(TAGW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .mode_freeze(mode_freeze), .mode_nowt(mode_nowt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wt_page(req_wt_page),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mode_fault(mode_fault),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_burst(bus_req_burst),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data), .bus_wb_ok(bus_wb_ok),
    .lk_idx(lk_idx), .lk_sel(lk_sel), .lk_tag(lk_tag), .lk_st(lk_st), .lk_word(lk_word),
    .ww_en(ww_en), .ww_idx(ww_idx), .ww_sel(ww_sel), .ww_data(ww_data),
    .mw_en(mw_en), .mw_idx(mw_idx), .mw_tag(mw_tag), .mw_st(mw_st)
  );
endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
  parameter int AW   = 32,
  parameter int OFFW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_freeze,
  input logic          mode_nowt,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mode_fault,
  input logic          bus_req_valid,
  input logic          bus_req_ready,
  input logic          bus_req_write,
  input logic          bus_req_burst,
  input logic [AW-1:0] bus_req_addr
);
  p_fault_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |-> $past(req_valid && req_ready && !mode_freeze && mode_nowt));

  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |-> (!bus_req_valid && !rsp_valid));

  p_busy_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !req_ready);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=>
      (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_write) && $stable(bus_req_burst)));

  p_freeze_no_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mode_freeze) |=> !(bus_req_valid && bus_req_burst));

  p_burst_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_burst) |->
      (bus_req_addr[OFFW-1:0] == '0 && !bus_req_write));

  p_rsp_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && !bus_req_valid));
endmodule

bind mode_cache_ctrl cc_checker #(.AW(AW), .OFFW($clog2(LINE_BYTES))) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_freeze(mode_freeze), .mode_nowt(mode_nowt),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mode_fault(mode_fault), .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_req_write(bus_req_write), .bus_req_burst(bus_req_burst), .bus_req_addr(bus_req_addr)
);

// File: tb/tb_mode_cache_ctrl.sv
module tb_mode_cache_ctrl;
  localparam int AW = 32, DW = 64, LINES = 16, IDXW = 4, TAGW = 23;
  localparam int ST_I = 0, ST_S = 1, ST_E = 2, ST_M = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_freeze = 0, mode_nowt = 0, req_valid = 0, req_write = 0, req_wt_page = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_rsp_data = '0;
  logic bus_req_ready = 0, bus_rsp_valid = 0, bus_wb_ok = 0;
  logic req_ready, rsp_valid, mode_fault, bus_req_valid, bus_req_write, bus_req_burst;
  logic [AW-1:0] bus_req_addr;
  logic [DW-1:0] rsp_rdata, bus_req_wdata;

  always #4 clk = ~clk;

  mode_cache_ctrl dut (.*);

  int n_chk = 0, n_bad = 0;
  int wb_force = -1;
  bit done = 0;
  int            m_st  [LINES];
  logic [TAGW-1:0] m_tag [LINES];
  logic [DW-1:0] m_dat [LINES][4];
  logic [DW-1:0] mem [logic [AW-1:0]];

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    if (mem.exists(a)) return mem[a];
    return {a ^ 32'h5A5A_0F0F, ~a};
  endfunction

  function automatic logic [AW-1:0] mk_addr(input int t, input int i, input int w);
    return {TAGW'(t), IDXW'(i), 2'(w), 3'b000};
  endfunction

  task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic bit pick_wb();
    if (wb_force >= 0) return wb_force[0];
    return 1'($urandom % 2);
  endfunction

  task automatic stall_req();
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk("R12 request held", {bus_req_valid, req_ready}, 2'b10);
    end
  endtask

  task automatic txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     input bit wtp, input bit frz, input bit nwt);
    int idx, sel; logic [TAGW-1:0] tg; bit hit, burst, wb, prom; logic [DW-1:0] d;
    idx = int'(a[8:5]); sel = int'(a[4:3]); tg = a[31:9];
    hit = (m_st[idx] != ST_I) && (m_tag[idx] == tg);
    chk("R12 ready before request", req_ready, 1);
    mode_freeze = frz; mode_nowt = nwt; req_valid = 1; req_write = wr;
    req_addr = a; req_wdata = wd; req_wt_page = wtp;
    @(negedge clk);
    req_valid = 0;
    if (!frz && nwt) begin
      chk("R10 fault pulse", {mode_fault, bus_req_valid, rsp_valid}, 3'b100);
      @(negedge clk);
      chk("R10 fault one cycle", mode_fault, 0);
      return;
    end
    chk("R10 no fault in legal mode", mode_fault, 0);
    if (!wr && hit) begin
      chk("R2 hit response", {rsp_valid, bus_req_valid, req_ready}, 3'b101);
      chk("R2/R6 hit data", rsp_rdata, m_dat[idx][sel]);
    end else if (!wr) begin
      burst = !frz;
      chk(burst ? "R3 burst request" : "R5 single request",
          {bus_req_valid, bus_req_write, bus_req_burst}, {2'b10, burst});
      chk("R3/R5 read address", bus_req_addr, burst ? {a[31:5], 5'b0} : a);
      stall_req();
      bus_req_ready = 1; @(negedge clk); bus_req_ready = 0;
      wb = 0;
      for (int b = 0; b < (burst ? 4 : 1); b++) begin
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk("R12 busy during beats", {req_ready, rsp_valid}, 2'b00);
        end
        wb = pick_wb();
        d = mem_rd(burst ? {a[31:5], 2'(b), 3'b0} : a);
        bus_rsp_valid = 1; bus_rsp_data = d; bus_wb_ok = wb;
        @(negedge clk);
        bus_rsp_valid = 0;
        if (burst) m_dat[idx][b] = d;
      end
      chk(burst ? "R3 fill response" : "R5 single response", {rsp_valid, req_ready}, 2'b11);
      chk("R3/R5 read data", rsp_rdata, mem_rd(a));
      if (burst) begin m_tag[idx] = tg; m_st[idx] = wb ? ST_E : ST_S; end
    end else begin
      if (hit) m_dat[idx][sel] = wd;
      if (hit && (m_st[idx] == ST_E || m_st[idx] == ST_M)) begin
        chk("R8 silent write hit", {bus_req_valid, rsp_valid, req_ready}, 3'b001);
        m_st[idx] = ST_M;
      end else begin
        chk("R7 external write", {bus_req_valid, bus_req_write, bus_req_burst}, 3'b110);
        chk("R7 write address", bus_req_addr, a);
        chk("R7 write data", bus_req_wdata, wd);
        prom = hit && !nwt && !wtp;
        stall_req();
        wb = pick_wb();
        bus_req_ready = 1; bus_wb_ok = wb; @(negedge clk); bus_req_ready = 0;
        chk("R7 ready after write", {req_ready, bus_req_valid}, 2'b10);
        mem[a] = wd;
        if (prom && wb) m_st[idx] = ST_E;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20251));
    for (int i = 0; i < LINES; i++) m_st[i] = ST_I;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {req_ready, bus_req_valid, rsp_valid, mode_fault}, 4'b1000);
    // R1: first read of any line misses and fills
    wb_force = 1;
    txn(0, mk_addr(1, 2, 3), 0, 0, 0, 0);
    txn(0, mk_addr(1, 2, 1), 0, 0, 0, 0);          // R2 hit after fill
    txn(1, mk_addr(1, 2, 1), 64'h1111, 0, 0, 0);   // R8 Exclusive: silent
    txn(0, mk_addr(1, 2, 1), 0, 0, 0, 0);          // R6 read-back
    // R4/R9: Shared fill, promotion
    wb_force = 0;
    txn(0, mk_addr(2, 3, 0), 0, 0, 0, 0);          // fills Shared
    txn(1, mk_addr(2, 3, 2), 64'h2222, 0, 0, 0);   // R7 external, no promotion
    wb_force = 1;
    txn(1, mk_addr(2, 3, 2), 64'h3333, 1, 0, 0);   // R9 page write-through blocks it
    txn(1, mk_addr(2, 3, 2), 64'h4444, 0, 1, 0);   // R9 freeze mode promotes
    txn(1, mk_addr(2, 3, 2), 64'h5555, 0, 1, 0);   // R8 now silent
    // R5: frozen miss does not allocate
    txn(0, mk_addr(0, 7, 2), 0, 0, 1, 0);
    txn(0, mk_addr(0, 7, 2), 0, 0, 1, 1);
    // R11: existing lines still hit in full-off mode
    txn(0, mk_addr(1, 2, 3), 0, 0, 1, 1);
    // R10: illegal mode touches nothing, then line still hits
    txn(1, mk_addr(1, 2, 3), 64'hDEAD, 0, 0, 1);
    txn(0, mk_addr(1, 2, 3), 0, 0, 0, 0);
    // R7: write miss does not allocate
    txn(1, mk_addr(0, 9, 0), 64'h7777, 0, 0, 0);
    txn(0, mk_addr(0, 9, 0), 0, 0, 1, 0);
    wb_force = -1;
    for (int k = 0; k < 500; k++) begin
      int r; bit f, n;
      r = $urandom % 10;
      f = (r >= 6 && r <= 8); n = (r >= 8);
      txn(1'($urandom % 2), mk_addr($urandom % 3, $urandom % 6, $urandom % 4),
          {$urandom, $urandom}, 1'($urandom % 4 == 0), f, n);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule